// File: doc/BRIEF.md
# Non-redundant radix-4 signed-digit coefficient encoder

This block turns a two's-complement coefficient of 2K bits into K radix-4 digits. A multiplier that uses fixed coefficients can store these digits in place of the raw value. Each of the K-1 lower digits is carried on two wires. The ±1 wire (`dig_lo`) has unit weight and the ±2 wire (`dig_hi`) has weight two. The `mode` input decides the sign each wire takes.

With `mode` = 0 a lower digit is `dig_lo - 2*dig_hi`, which lies in {-2,-1,0,1}. With `mode` = 1 it is `2*dig_hi - dig_lo`, which lies in {-1,0,1,2}. The digits come from a chain of half adders, with one carry bit moving up from the least significant bit.

- In mode 0, an ordinary half adder handles each even bit. A signed half adder handles each odd bit. Its carry is positive and its sum is negative, so the odd-bit carry is the OR of its inputs.
- Mode 1 swaps the two adder kinds.
- The most significant digit takes in the top two coefficient bits and the final carry. It is given in sign/one/two Booth form with values in {-2..2}, so every two's-complement value, including the most negative, can be represented.

The encoding is combinational. When `REG_OUT` = 1 (the default) the digit outputs are registered and appear one clock after the inputs.

Top module: `nr4sd_encoder`

## Requirements
- R1: With `REG_OUT` = 1, every digit output is 0 while `rst_n` is low, whatever the inputs.
- R2: With `mode` = 0, lower digit j has value `dig_lo[j] - 2*dig_hi[j]`. The sum over all digits, each scaled by 4^j, equals the signed coefficient.
- R3: With `mode` = 1, lower digit j has value `2*dig_hi[j] - dig_lo[j]`. The same weighted sum equals the signed coefficient.
- R4: The top digit is in Booth form: its value is (-1)^`msd_neg`·(`msd_one` + 2·`msd_two`). `msd_one` and `msd_two` are never both 1, and `msd_neg` is 1 only when one of them is 1.
- R5: The weighted sum is exact over the whole range, including the most negative coefficient (only bit 2K-1 set) and the most positive coefficient (all bits set except bit 2K-1). The top digit carries weight 4^(K-1).
- R6: With `REG_OUT` = 1, the outputs in the cycle after a rising clock edge encode the `coef` and `mode` sampled at that edge. With `REG_OUT` = 0 they follow the inputs combinationally.
- R7: A zero coefficient produces all-zero digit outputs in both modes.
- R8: `dig_lo[0]` equals coefficient bit 0 in both modes, because the incoming carry of the chain is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| mode | input | 1 | 0: digits in {-2..1}; 1: digits in {-1..2} |
| coef | input | 2K | Two's-complement coefficient |
| dig_lo | output | K-1 | Unit-weight wire of lower digits 0..K-2 |
| dig_hi | output | K-1 | Weight-two wire of lower digits 0..K-2 |
| msd_neg | output | 1 | Sign of the top digit |
| msd_one | output | 1 | Top digit magnitude is 1 |
| msd_two | output | 1 | Top digit magnitude is 2 |

## Verification
The assertions check four things on every cycle: the legality of the top digit's Booth form, the exact weighted-sum identity against the delayed coefficient, the zero-in/zero-out case and the bit-0 relation. Some behaviour only the bench scenarios can show:
- the reset value, since the assertions are disabled during reset;
- how the two modes behave on the extreme coefficients;
- that a stream of changing inputs and modes is matched one-to-one, with the stated latency, by a stream of encodings.

// File: rtl/nr4sd_encoder.sv
module nr4sd_encoder #(
  parameter int K       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode,
  input  logic [2*K-1:0] coef,
  output logic [K-2:0]   dig_lo,
  output logic [K-2:0]   dig_hi,
  output logic           msd_neg,
  output logic           msd_one,
  output logic           msd_two
);
  localparam int W = 2*K;

  logic [W-2:0] cy;
  logic [K-2:0] lo_n, hi_n;
  logic         neg_n, one_n, two_n;
  logic [1:0]   top_s;

  assign cy[0] = 1'b0;

  for (genvar j = 0; j < K-1; j++) begin : g_dig
    logic be, bo, co;
    assign be = coef[2*j];
    assign bo = coef[2*j+1];
    assign co = cy[2*j+1];
    assign lo_n[j]    = be ^ cy[2*j];
    assign hi_n[j]    = bo ^ co;
    assign cy[2*j+1]  = mode ? (be | cy[2*j]) : (be & cy[2*j]);
    assign cy[2*j+2]  = mode ? (bo & co)      : (bo | co);
  end

  assign top_s = {1'b0, coef[W-2]} + {1'b0, cy[W-2]};

  always_comb begin
    if (!coef[W-1]) begin
      neg_n = 1'b0;
      one_n = (top_s == 2'd1);
      two_n = (top_s == 2'd2);
    end else begin
      neg_n = (top_s != 2'd2);
      one_n = (top_s == 2'd1);
      two_n = (top_s == 2'd0);
    end
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dig_lo  <= '0;
        dig_hi  <= '0;
        msd_neg <= 1'b0;
        msd_one <= 1'b0;
        msd_two <= 1'b0;
      end else begin
        dig_lo  <= lo_n;
        dig_hi  <= hi_n;
        msd_neg <= neg_n;
        msd_one <= one_n;
        msd_two <= two_n;
      end
    end
  end else begin : g_comb
    assign dig_lo  = lo_n;
    assign dig_hi  = hi_n;
    assign msd_neg = neg_n;
    assign msd_one = one_n;
    assign msd_two = two_n;
  end
endmodule

// File: rtl/nr4sd_encoder_checker.sv
module nr4sd_encoder_checker #(
  parameter int K       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mode,
  input logic [2*K-1:0] coef,
  input logic [K-2:0]   dig_lo,
  input logic [K-2:0]   dig_hi,
  input logic           msd_neg,
  input logic           msd_one,
  input logic           msd_two
);
  logic [2*K-1:0] ref_coef;
  logic           ref_mode;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_coef <= '0;
        ref_mode <= 1'b0;
      end else begin
        ref_coef <= coef;
        ref_mode <= mode;
      end
    end
  end else begin : g_nodly
    assign ref_coef = coef;
    assign ref_mode = mode;
  end

  function automatic longint weighted(input logic [K-2:0] lo, input logic [K-2:0] hi,
                                      input logic m, input logic n, input logic o,
                                      input logic t);
    longint acc = 0;
    longint mag;
    for (int j = 0; j < K-1; j++) begin
      if (m) acc += (2*longint'(hi[j]) - longint'(lo[j])) <<< (2*j);
      else   acc += (longint'(lo[j]) - 2*longint'(hi[j])) <<< (2*j);
    end
    mag = longint'(o) + 2*longint'(t);
    acc += (n ? -mag : mag) <<< (2*(K-1));
    return acc;
  endfunction

  // R4
  a_r4_msd_single: assert property (@(posedge clk) disable iff (!rst_n)
    !(msd_one && msd_two));
  // R4
  a_r4_sign_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    msd_neg |-> (msd_one || msd_two));
  // R2, R3, R5, R6
  a_r2_r3_value: assert property (@(posedge clk) disable iff (!rst_n)
    weighted(dig_lo, dig_hi, ref_mode, msd_neg, msd_one, msd_two)
      == longint'($signed(ref_coef)));
  // R7
  a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_coef == '0) |-> (dig_lo == '0 && dig_hi == '0 && !msd_neg && !msd_one && !msd_two));
  // R8
  a_r8_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
    dig_lo[0] == ref_coef[0]);
endmodule

bind nr4sd_encoder nr4sd_encoder_checker #(.K(K), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .coef(coef),
  .dig_lo(dig_lo), .dig_hi(dig_hi),
  .msd_neg(msd_neg), .msd_one(msd_one), .msd_two(msd_two)
);

// File: tb/nr4sd_encoder_bench.sv
module nr4sd_encoder_bench;
  localparam int K       = 8;
  localparam bit REG_OUT = 1'b1;
  localparam int W       = 2*K;

  typedef struct {
    logic [W-1:0] c;
    logic         m;
  } item_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           mode = 1'b0;
  logic [W-1:0]   coef = '0;
  logic [K-2:0]   dig_lo, dig_hi;
  logic           msd_neg, msd_one, msd_two;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  nr4sd_encoder #(.K(K), .REG_OUT(REG_OUT)) u_nr4sd_encoder (
    .clk(clk), .rst_n(rst_n), .mode(mode), .coef(coef),
    .dig_lo(dig_lo), .dig_hi(dig_hi),
    .msd_neg(msd_neg), .msd_one(msd_one), .msd_two(msd_two)
  );

  function automatic longint decode(input logic m);
    longint acc = 0;
    longint mag;
    for (int j = 0; j < K-1; j++) begin
      if (m) acc += (2*longint'(dig_hi[j]) - longint'(dig_lo[j])) * (longint'(1) << (2*j));
      else   acc += (longint'(dig_lo[j]) - 2*longint'(dig_hi[j])) * (longint'(1) << (2*j));
    end
    mag = longint'(msd_one) + 2*longint'(msd_two);
    acc += (msd_neg ? -mag : mag) * (longint'(1) << (2*(K-1)));
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] c, input logic m);
    item_t it;
    @(negedge clk);
    coef = c;
    mode = m;
    it.c = c;
    it.m = m;
    q.push_back(it);
  endtask

  // monitor: R6 latency is implied by popping one item per edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && q.size() > 0) begin
        item_t it;
        longint exp_v, act_v;
        it = q.pop_front();
        exp_v = longint'($signed(it.c));
        act_v = decode(it.m);
        check(act_v == exp_v, it.m ? "R3/R5/R6 value" : "R2/R5/R6 value", act_v, exp_v);
        check(!(msd_one && msd_two) && (!msd_neg || msd_one || msd_two), "R4 booth form",
              {msd_neg, msd_one, msd_two}, 0);
        check(dig_lo[0] == it.c[0], "R8 low bit", dig_lo[0], it.c[0]);
        if (it.c == '0)
          check({dig_lo, dig_hi, msd_neg, msd_one, msd_two} == '0, "R7 zero",
                {dig_lo, dig_hi, msd_neg, msd_one, msd_two}, 0);
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hang expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf = 32'h1ACE_B00F;
    // R1: reset holds outputs at zero
    coef = '1;
    mode = 1'b1;
    repeat (3) @(negedge clk);
    if (REG_OUT)
      check({dig_lo, dig_hi, msd_neg, msd_one, msd_two} == '0, "R1 reset",
            {dig_lo, dig_hi, msd_neg, msd_one, msd_two}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int m = 0; m < 2; m++) begin
      drive('0, m[0]);                          // R7
      drive('1, m[0]);                          // -1
      drive({1'b1, {(W-1){1'b0}}}, m[0]);       // R5 min
      drive({1'b0, {(W-1){1'b1}}}, m[0]);       // R5 max
      drive({(W/2){2'b01}}, m[0]);
      drive({(W/2){2'b10}}, m[0]);
      drive({(W/2){2'b11}} ^ {(W/4){4'b0011}}, m[0]);
      for (int b = 0; b < W; b++) drive(W'(1) << b, m[0]);
    end
    for (int i = 0; i < 3000; i++) begin
      lf ^= lf << 13;
      lf ^= lf >> 17;
      lf ^= lf << 5;
      drive(lf[W-1:0], lf[W]);                  // R2 R3 mixed modes
    end
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R6 drained", q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule